// File: doc/BRIEF.md
# Clock Output Enable and Shutdown Controller

This block decides, for every clock output of a clock generator, how that output's pad is driven. One shared external control pin and a set of per-output configuration bits are combined into one of four drive states per output: running, high impedance, parked at a fixed low level, or stopped low for a chip-wide power-down. The pin plays one of two roles chosen by a configuration bit. It can be a global power-down request, or it can be an output enable whose active level is programmable.

The pin is asynchronous, so it passes through a synchroniser first. A new drive state for an output is applied only on a cycle in which that output's divided clock is low. This keeps enables and disables from clipping a clock pulse. When the power-down request is withdrawn, the block does not restart the outputs at once. It raises a wake request and keeps every output stopped until the power logic acknowledges. Each output also gets a clock-gate signal that is high exactly when the output is running.

Top module: `clkout_enable_ctrl`

## Requirements
- R1: The control pin passes through two synchronising flops. With the divided clock low, a pin change sampled on one rising edge reaches `drive_mode` on the third rising edge, and not before.
- R2: When `pin_role_sd`=0 the pin is an output enable. With `pin_pol_hi`=0 a low pin enables and a high pin disables. With `pin_pol_hi`=1 the sense is inverted. A floating pin reads 0, so with `pin_pol_hi`=0 the outputs keep running.
- R3: When `pin_role_sd`=1 and the pin is high, every output takes code 2'b00 (stopped low) and `core_pwr_dn` is 1. `pin_pol_hi` has no effect in this role.
- R4: Outside power-down, an output whose `out_live` bit is 0 takes code 2'b10 (high impedance), whatever its `park_on_dis` bit and the pin level.
- R5: With `out_live`=1 and the pin disabling outputs, an output with `park_on_dis`=0 keeps code 2'b01 (running) and an output with `park_on_dis`=1 takes code 2'b11 (parked low).
- R6: An output's `drive_mode` changes only on an edge where its `div_clk_lvl` bit is 0. Its `clk_gate` bit is 1 exactly when its mode is 2'b01.
- R7: When the power-down request goes away, `core_pwr_dn` falls and `wake_req` rises. All outputs stay at 2'b00 until `wake_ack` is sampled high. The modes then resume on the next edge at which each divided clock is low.
- R8: While reset is asserted, every output is at 2'b10, all `clk_gate` bits are 0, and `wake_req` and `core_pwr_dn` are 0.
- R9: Power-down takes priority over `out_live`=0: an output configured for high impedance is still stopped low (2'b00) while powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ctl_pin | input | 1 | Raw shared control pin (weak pull-down) |
| pin_role_sd | input | 1 | 1: pin requests power-down; 0: pin is an output enable |
| pin_pol_hi | input | 1 | Output-enable polarity: 1 active high, 0 active low |
| out_live | input | NUM_OUT | Per output: 0 forces high impedance |
| park_on_dis | input | NUM_OUT | Per output: 1 parks the output low when the pin disables outputs |
| div_clk_lvl | input | NUM_OUT | Level of each divided output clock, in the clk domain |
| wake_ack | input | 1 | Acknowledge from power logic that the core is back up |
| drive_mode | output | 2*NUM_OUT | Per output drive code: 00 stop, 01 run, 10 high impedance, 11 park |
| clk_gate | output | NUM_OUT | Per output clock gate enable |
| core_pwr_dn | output | 1 | Core power-down request |
| wake_req | output | 1 | Wake request pending acknowledge |

## Verification
A pin change is due at `drive_mode` and `clk_gate` on the third rising edge after it is sampled. The same holds for `core_pwr_dn` and `wake_req`. A `wake_ack` sampled on one edge moves the block out of the wake state on that edge, and the modes follow on the next edge where each divided clock is low. The bench's reference model carries the two-sample pin history, the power state and the per-output modes as plain variables. It advances them on each rising edge and compares at the falling edge. Directed checks hold the divided clocks low to count the R1 latency exactly, and hold one divided clock high to show that its mode is frozen.

// File: rtl/oe_sd_pkg.sv
package oe_sd_pkg;

  typedef enum logic [1:0] {
    DRV_STOP = 2'b00,
    DRV_RUN  = 2'b01,
    DRV_HIZ  = 2'b10,
    DRV_PARK = 2'b11
  } drv_mode_e;

  typedef enum logic [1:0] {
    PW_RUN  = 2'b00,
    PW_SHUT = 2'b01,
    PW_WAKE = 2'b10
  } pwr_state_e;

endpackage

// File: rtl/oe_pin_sync.sv
module oe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_sync
);

  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_d;

  always_comb begin
    chain_d = {chain_q[MSB-1:0], pin_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign pin_sync = chain_q[MSB];

endmodule

// File: rtl/oe_pwr_fsm.sv
module oe_pwr_fsm
  import oe_sd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sd_req,
  input  logic wake_ack,
  output logic force_stop,
  output logic core_pwr_dn,
  output logic wake_req
);

  pwr_state_e state_q;
  pwr_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_RUN:  if (sd_req) state_d = PW_SHUT;
      PW_SHUT: if (!sd_req) state_d = PW_WAKE;
      PW_WAKE: begin
        if (sd_req)        state_d = PW_SHUT;
        else if (wake_ack) state_d = PW_RUN;
      end
      default: state_d = PW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  assign force_stop  = sd_req | (state_q != PW_RUN);
  assign core_pwr_dn = (state_q == PW_SHUT);
  assign wake_req    = (state_q == PW_WAKE);

  // R3: a power-down request is reflected on the next edge
  a_r3_pwr_dn_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sd_req |=> core_pwr_dn);

  // R7: leaving power-down raises the wake request
  a_r7_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_dn && !sd_req) |=> wake_req);

  // R7: wake request holds until acknowledged
  a_r7_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack && !sd_req) |=> wake_req);

endmodule

// File: rtl/oe_lane.sv
module oe_lane
  import oe_sd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_stop,
  input  logic       pin_disable,
  input  logic       live,
  input  logic       park_en,
  input  logic       div_lvl,
  output logic [1:0] mode,
  output logic       gate
);

  drv_mode_e mode_q;
  drv_mode_e mode_d;
  drv_mode_e target;
  logic      upd_en;

  always_comb begin
    if (force_stop)               target = DRV_STOP;
    else if (!live)               target = DRV_HIZ;
    else if (pin_disable && park_en) target = DRV_PARK;
    else                          target = DRV_RUN;
  end

  assign upd_en = !div_lvl;

  always_comb begin
    mode_d = mode_q;
    if (upd_en) mode_d = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DRV_HIZ;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;
  assign gate = (mode_q == DRV_RUN);

  // R6: mode frozen while divided clock is high
  a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    div_lvl |=> $stable(mode));

  // R3 and R9: stop wins over every other setting
  a_r9_stop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stop && !div_lvl) |=> (mode == 2'b00));

  // R4: not live means high impedance outside power-down
  a_r4_hiz_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_stop && !live && !div_lvl) |=> (mode == 2'b10));

  // R5: parked when disabled with park enabled
  a_r5_park_when_dis: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_stop && live && pin_disable && park_en && !div_lvl) |=> (mode == 2'b11));

  // R5: running when disabled without park
  a_r5_run_without_park: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_stop && live && !park_en && !div_lvl) |=> (mode == 2'b01 && gate));

endmodule

// File: rtl/clkout_enable_ctrl.sv
module clkout_enable_ctrl
  import oe_sd_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_pin,
  input  logic                 pin_role_sd,
  input  logic                 pin_pol_hi,
  input  logic [NUM_OUT-1:0]   out_live,
  input  logic [NUM_OUT-1:0]   park_on_dis,
  input  logic [NUM_OUT-1:0]   div_clk_lvl,
  input  logic                 wake_ack,
  output logic [2*NUM_OUT-1:0] drive_mode,
  output logic [NUM_OUT-1:0]   clk_gate,
  output logic                 core_pwr_dn,
  output logic                 wake_req
);

  localparam int MODE_W = 2;

  logic pin_s;
  logic sd_req;
  logic pin_disable;
  logic force_stop;

  oe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (ctl_pin),
    .pin_sync (pin_s)
  );

  assign sd_req      = pin_role_sd & pin_s;
  assign pin_disable = !pin_role_sd & (pin_s ^ pin_pol_hi);

  oe_pwr_fsm u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_req      (sd_req),
    .wake_ack    (wake_ack),
    .force_stop  (force_stop),
    .core_pwr_dn (core_pwr_dn),
    .wake_req    (wake_req)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    logic [MODE_W-1:0] lane_mode;
    oe_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_stop  (force_stop),
      .pin_disable (pin_disable),
      .live        (out_live[i]),
      .park_en     (park_on_dis[i]),
      .div_lvl     (div_clk_lvl[i]),
      .mode        (lane_mode),
      .gate        (clk_gate[i])
    );
    assign drive_mode[MODE_W*i +: MODE_W] = lane_mode;
  end

  // R3: no output runs while the core is powered down
  a_r3_no_run_in_pwr_dn: assert property (@(posedge clk) disable iff (!rst_n)
    $past(core_pwr_dn) && core_pwr_dn && $past(div_clk_lvl) == '0 |-> clk_gate == '0);

  // R7: no output runs while waiting for the wake acknowledge
  a_r7_no_run_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wake_req) && wake_req |-> clk_gate == '0);

endmodule

// File: tb/sim_clkout_enable_ctrl.sv
`timescale 1ns/1ps
module sim_clkout_enable_ctrl;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ctl_pin, role_sd, pol_hi, wake_ack;
  logic [N-1:0] live, park, div_lvl;
  logic [2*N-1:0] drive_mode;
  logic [N-1:0] clk_gate;
  logic         core_pwr_dn, wake_req;

  always #4 clk = ~clk;

  clkout_enable_ctrl #(.NUM_OUT(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .pin_role_sd(role_sd),
    .pin_pol_hi(pol_hi), .out_live(live), .park_on_dis(park),
    .div_clk_lvl(div_lvl), .wake_ack(wake_ack), .drive_mode(drive_mode),
    .clk_gate(clk_gate), .core_pwr_dn(core_pwr_dn), .wake_req(wake_req)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // divided clock stimulus: 0 toggle, 1 all low; hold forces a bit high
  int div_style = 0;
  logic [N-1:0] hold = '0;

  // reference model state
  int m_s1, m_s2, m_st;   // m_st: 0 running, 1 powered down, 2 waking
  int m_mode[N];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_st = 0;
      for (int i = 0; i < N; i++) m_mode[i] = 2;
    end else begin
      bit sd, dis, fs;
      sd  = role_sd && (m_s2 == 1);
      dis = !role_sd && ((m_s2 == 1) != pol_hi);
      fs  = sd || (m_st != 0);
      for (int i = 0; i < N; i++) begin
        if (!div_lvl[i]) begin
          if (fs)                      m_mode[i] = 0;
          else if (!live[i])           m_mode[i] = 2;
          else if (dis && park[i])     m_mode[i] = 3;
          else                         m_mode[i] = 1;
        end
      end
      if (m_st == 0 && sd) m_st = 1;
      else if (m_st == 1 && !sd) m_st = 2;
      else if (m_st == 2) begin
        if (sd) m_st = 1;
        else if (wake_ack) m_st = 0;
      end
      m_s2 = m_s1;
      m_s1 = ctl_pin;
    end
  end

  // stimulus and per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < N; i++)
      div_lvl[i] <= hold[i] ? 1'b1 : (div_style == 1 ? 1'b0 : 1'(((cyc / (i + 1)) % 2)));
    if (rst_n && cyc > 2) begin
      for (int i = 0; i < N; i++) begin
        string tg;
        if (m_st != 0)        tg = "R9";
        else if (!live[i])    tg = "R4";
        else                  tg = "R5";
        chk(tg, drive_mode[2*i +: 2], m_mode[i]);
        chk("R6", clk_gate[i], m_mode[i] == 1);
      end
      chk("R7", wake_req, m_st == 2);
      chk("R3", core_pwr_dn, m_st == 1);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk_modes(string tag, int e0, int e1, int e2, int e3);
    chk(tag, drive_mode[1:0], e0);
    chk(tag, drive_mode[3:2], e1);
    chk(tag, drive_mode[5:4], e2);
    chk(tag, drive_mode[7:6], e3);
  endtask

  initial begin
    rst_n = 0; ctl_pin = 0; role_sd = 0; pol_hi = 0; wake_ack = 0;
    live = '1; park = '0; div_lvl = '0;
    wait_cyc(4);
    // R8 reset state
    chk_modes("R8", 2, 2, 2, 2);
    chk("R8", clk_gate, 0);
    chk("R8", wake_req, 0);
    chk("R8", core_pwr_dn, 0);
    rst_n = 1;

    // R2 floating pin, active-low enable: all running
    wait_cyc(8);
    chk_modes("R2", 1, 1, 1, 1);
    chk("R2", clk_gate, 4'hF);

    // R5 disable with mixed park bits
    park = 4'b0101; ctl_pin = 1;
    wait_cyc(8);
    chk_modes("R5", 3, 1, 3, 1);

    // R2 active-high polarity: high pin enables, low disables
    pol_hi = 1;
    wait_cyc(8);
    chk_modes("R2", 1, 1, 1, 1);
    ctl_pin = 0;
    wait_cyc(8);
    chk_modes("R2", 3, 1, 3, 1);

    // R4 outputs not live stay high impedance, enabled or not
    live = 4'b0011; park = 4'hF;
    wait_cyc(8);
    chk_modes("R4", 3, 3, 2, 2);
    ctl_pin = 1;
    wait_cyc(8);
    chk_modes("R4", 1, 1, 2, 2);

    // R1 exact latency with divided clocks held low
    live = '1; pol_hi = 0; ctl_pin = 0; div_style = 1;
    wait_cyc(6);
    chk_modes("R1", 1, 1, 1, 1);
    ctl_pin = 1;           // sampled on the next rising edge
    wait_cyc(2);
    chk_modes("R1", 1, 1, 1, 1);
    wait_cyc(1);
    chk_modes("R1", 3, 3, 3, 3);

    // R6 a divided clock held high freezes its output
    ctl_pin = 0;
    wait_cyc(6);
    hold = 4'b0001;
    wait_cyc(2);
    ctl_pin = 1;
    wait_cyc(6);
    chk("R6", drive_mode[1:0], 1);
    chk("R6", drive_mode[3:2], 3);
    hold = '0;
    wait_cyc(3);
    chk("R6", drive_mode[1:0], 3);
    div_style = 0;

    // R3 and R9 power-down, polarity ignored, high-impedance overridden
    live = 4'b0011; role_sd = 1; ctl_pin = 1;
    wait_cyc(10);
    chk_modes("R9", 0, 0, 0, 0);
    chk("R3", core_pwr_dn, 1);
    pol_hi = 1;
    wait_cyc(6);
    chk_modes("R3", 0, 0, 0, 0);
    chk("R3", clk_gate, 0);

    // R7 wake handshake
    ctl_pin = 0;
    wait_cyc(10);
    chk("R7", wake_req, 1);
    chk("R7", core_pwr_dn, 0);
    chk_modes("R7", 0, 0, 0, 0);
    wake_ack = 1;
    wait_cyc(1);
    wake_ack = 0;
    wait_cyc(8);
    chk("R7", wake_req, 0);
    chk_modes("R7", 1, 1, 2, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule